// File: doc/BRIEF.md
# Slotted Shared-Memory Bus Arbiter

This block decides, one bus slot at a time, which of four requesters may use a single shared memory bus. The requesters are a display fetch engine, a coprocessor engine, a CPU and a peripheral DMA port. Slots alternate in parity. Odd slots belong to the display engine. Even slots go to the coprocessor, the CPU and the DMA port in fixed priority order.

While horizontal or vertical blanking is active, an odd slot that the display engine does not claim is offered to the other three requesters. Outside blanking, an unclaimed odd slot stays idle, which keeps display timing fixed.

Every grant covers exactly one slot and is decided again at each slot boundary. DMA is therefore displaced as soon as a higher requester asks. Each sharing requester has a wait counter that shows how many slots its current request has been refused. A separate expansion-memory grant for the CPU is held off while the CPU asks for the shared bus.

Top module: `slot_arbiter`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `slot_odd` is 0, every grant (including `exp_gnt`) is 0 and all wait counters are 0.
- R2: `slot_odd` inverts on every clock edge after reset. A value of 1 marks an odd slot and 0 marks an even slot.
- R3: Grants are registered. A grant for a slot is decided from the requests sampled at the edge that starts the slot. At most one of `gnt_disp`, `gnt_eng`, `gnt_cpu`, `gnt_dma` is 1 in any cycle, and a grant goes only to a requester whose request was sampled high.
- R4: Outside blanking, an odd slot goes to the display engine if it requests. Otherwise the slot stays idle, even if others request.
- R5: In an even slot the order of precedence is coprocessor, then CPU, then DMA. The display engine is never granted an even slot.
- R6: When `blank_h` or `blank_v` is sampled high, an odd slot still goes to the display engine if it requests. Otherwise it goes to the other three by the R5 order.
- R7: DMA receives a slot only when neither the coprocessor nor the CPU requests it. DMA may hold consecutive slots, odd ones included during blanking, while no higher requester asks.
- R8: At each edge, the wait counter of a coprocessor, CPU or DMA request that is refused a slot increases by one and saturates at 2^WAIT_W-1. The counter returns to 0 when that requester is granted or its request was sampled low.
- R9: `exp_gnt` is 1 in a slot only if `exp_req` was sampled high and `req_cpu` was sampled low at the edge that started the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_disp | input | 1 | Display fetch request |
| req_eng | input | 1 | Coprocessor engine request |
| req_cpu | input | 1 | CPU shared-memory request |
| req_dma | input | 1 | Peripheral DMA request |
| blank_h | input | 1 | Horizontal blanking active |
| blank_v | input | 1 | Vertical blanking active |
| exp_req | input | 1 | CPU expansion-memory request |
| slot_odd | output | 1 | Parity of the current slot (1 = odd) |
| gnt_disp | output | 1 | Display owns the current slot |
| gnt_eng | output | 1 | Coprocessor owns the current slot |
| gnt_cpu | output | 1 | CPU owns the current slot |
| gnt_dma | output | 1 | DMA owns the current slot |
| exp_gnt | output | 1 | CPU may use expansion memory this slot |
| wait_eng | output | WAIT_W | Slots refused to the pending coprocessor request |
| wait_cpu | output | WAIT_W | Slots refused to the pending CPU request |
| wait_dma | output | WAIT_W | Slots refused to the pending DMA request |

## Verification
Every output is registered. The slot parity, the four bus grants, the expansion grant and the wait counters all react at the first rising edge after a request or blanking change, so each result is due exactly one cycle after the stimulus. The bench changes inputs only just after a falling edge and lets one rising edge pass. It then compares the outputs at the following falling edge against a model that also advances once per edge, and it tracks the slot parity on its own rather than reading it from the design. The saturation and preemption cases run long enough that the counter limit and a DMA displacement both fall on slots whose parity is known in advance.

// File: rtl/slot_arbiter.sv
module slot_arbiter #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_disp,
  input  logic              req_eng,
  input  logic              req_cpu,
  input  logic              req_dma,
  input  logic              blank_h,
  input  logic              blank_v,
  input  logic              exp_req,
  output logic              slot_odd,
  output logic              gnt_disp,
  output logic              gnt_eng,
  output logic              gnt_cpu,
  output logic              gnt_dma,
  output logic              exp_gnt,
  output logic [WAIT_W-1:0] wait_eng,
  output logic [WAIT_W-1:0] wait_cpu,
  output logic [WAIT_W-1:0] wait_dma
);

  localparam logic [WAIT_W-1:0] WAIT_MAX = {WAIT_W{1'b1}};

  logic next_odd, blanking, open_slot;
  logic pick_disp, pick_eng, pick_cpu, pick_dma;

  assign next_odd  = ~slot_odd;
  assign blanking  = blank_h | blank_v;
  assign open_slot = ~next_odd | (blanking & ~req_disp);

  assign pick_disp = next_odd & req_disp;
  assign pick_eng  = open_slot & req_eng;
  assign pick_cpu  = open_slot & req_cpu & ~req_eng;
  assign pick_dma  = open_slot & req_dma & ~req_eng & ~req_cpu;

  function automatic logic [WAIT_W-1:0] bump(input logic [WAIT_W-1:0] cnt,
                                             input logic pend, input logic won);
    if (!pend || won)       return '0;
    else if (cnt == WAIT_MAX) return cnt;
    else                    return cnt + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_odd <= 1'b0;
      gnt_disp <= 1'b0;
      gnt_eng  <= 1'b0;
      gnt_cpu  <= 1'b0;
      gnt_dma  <= 1'b0;
      exp_gnt  <= 1'b0;
      wait_eng <= '0;
      wait_cpu <= '0;
      wait_dma <= '0;
    end else begin
      slot_odd <= next_odd;
      gnt_disp <= pick_disp;
      gnt_eng  <= pick_eng;
      gnt_cpu  <= pick_cpu;
      gnt_dma  <= pick_dma;
      exp_gnt  <= exp_req & ~req_cpu;
      wait_eng <= bump(wait_eng, req_eng, pick_eng);
      wait_cpu <= bump(wait_cpu, req_cpu, pick_cpu);
      wait_dma <= bump(wait_dma, req_dma, pick_dma);
    end
  end

endmodule

// File: rtl/slot_arbiter_chk.sv
module slot_arbiter_chk #(
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_disp,
  input logic              req_eng,
  input logic              req_cpu,
  input logic              req_dma,
  input logic              blank_h,
  input logic              blank_v,
  input logic              exp_req,
  input logic              slot_odd,
  input logic              gnt_disp,
  input logic              gnt_eng,
  input logic              gnt_cpu,
  input logic              gnt_dma,
  input logic              exp_gnt,
  input logic [WAIT_W-1:0] wait_eng,
  input logic [WAIT_W-1:0] wait_cpu,
  input logic [WAIT_W-1:0] wait_dma
);

  logic started;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;

  assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_disp, gnt_eng, gnt_cpu, gnt_dma}));

  assert_parity_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> slot_odd != $past(slot_odd));

  assert_grant_had_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (started && gnt_cpu) |-> $past(req_cpu));

  assert_no_disp_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_odd |-> !gnt_disp);

  assert_idle_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (started && slot_odd && !$past(blank_h) && !$past(blank_v))
      |-> !(gnt_eng || gnt_cpu || gnt_dma));

  assert_dma_yield_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (started && gnt_dma) |-> !$past(req_eng) && !$past(req_cpu));

  assert_blank_disp_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (started && slot_odd && $past(req_disp)) |-> gnt_disp);

  assert_wait_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_dma |-> wait_dma == '0);

  assert_exp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (started && exp_gnt) |-> !$past(req_cpu) && $past(exp_req));

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> !slot_odd && !exp_gnt && wait_eng == '0 && wait_cpu == '0);

endmodule

bind slot_arbiter slot_arbiter_chk #(.WAIT_W(WAIT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_disp(req_disp), .req_eng(req_eng),
  .req_cpu(req_cpu), .req_dma(req_dma), .blank_h(blank_h), .blank_v(blank_v),
  .exp_req(exp_req), .slot_odd(slot_odd), .gnt_disp(gnt_disp),
  .gnt_eng(gnt_eng), .gnt_cpu(gnt_cpu), .gnt_dma(gnt_dma),
  .exp_gnt(exp_gnt), .wait_eng(wait_eng), .wait_cpu(wait_cpu),
  .wait_dma(wait_dma));

// File: tb/test_slot_arbiter.sv
module test_slot_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_W = 4;
  localparam logic [WAIT_W-1:0] WMAX = {WAIT_W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_disp = 0, req_eng = 0, req_cpu = 0, req_dma = 0;
  logic blank_h = 0, blank_v = 0, exp_req = 0;
  logic slot_odd, gnt_disp, gnt_eng, gnt_cpu, gnt_dma, exp_gnt;
  logic [WAIT_W-1:0] wait_eng, wait_cpu, wait_dma;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  logic m_par;
  logic [3:0] m_gnt;
  logic m_exp;
  logic [WAIT_W-1:0] m_we, m_wc, m_wd;

  slot_arbiter #(.WAIT_W(WAIT_W)) i_slot_arbiter (
    .clk(clk), .rst_n(rst_n), .req_disp(req_disp), .req_eng(req_eng),
    .req_cpu(req_cpu), .req_dma(req_dma), .blank_h(blank_h),
    .blank_v(blank_v), .exp_req(exp_req), .slot_odd(slot_odd),
    .gnt_disp(gnt_disp), .gnt_eng(gnt_eng), .gnt_cpu(gnt_cpu),
    .gnt_dma(gnt_dma), .exp_gnt(exp_gnt), .wait_eng(wait_eng),
    .wait_cpu(wait_cpu), .wait_dma(wait_dma));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WAIT_W-1:0] nxt(input logic [WAIT_W-1:0] c,
                                            input logic p, input logic w);
    if (!p || w) return '0;
    return (c == WMAX) ? c : c + 1'b1;
  endfunction

  task automatic step(input string tag);
    logic open;
    @(posedge clk);
    m_par = ~m_par;
    open = !m_par || ((blank_h || blank_v) && !req_disp);
    m_gnt[3] = m_par && req_disp;
    m_gnt[2] = open && req_eng;
    m_gnt[1] = open && req_cpu && !req_eng;
    m_gnt[0] = open && req_dma && !req_eng && !req_cpu;
    m_exp = exp_req && !req_cpu;
    m_we = nxt(m_we, req_eng, m_gnt[2]);
    m_wc = nxt(m_wc, req_cpu, m_gnt[1]);
    m_wd = nxt(m_wd, req_dma, m_gnt[0]);
    @(negedge clk);
    check(slot_odd == m_par, {tag, " R2 parity"}, slot_odd, m_par);
    check({gnt_disp, gnt_eng, gnt_cpu, gnt_dma} == m_gnt, {tag, " grants"},
          {gnt_disp, gnt_eng, gnt_cpu, gnt_dma}, m_gnt);
    check(exp_gnt == m_exp, {tag, " R9 exp"}, exp_gnt, m_exp);
    check({wait_eng, wait_cpu, wait_dma} == {m_we, m_wc, m_wd}, {tag, " R8 waits"},
          {wait_eng, wait_cpu, wait_dma}, {m_we, m_wc, m_wd});
  endtask

  task automatic set_req(input logic d, e, c, m, input logic bh, bv);
    req_disp = d; req_eng = e; req_cpu = c; req_dma = m;
    blank_h = bh; blank_v = bv;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check({slot_odd, gnt_disp, gnt_eng, gnt_cpu, gnt_dma, exp_gnt} == 0,
          "R1 in reset", {slot_odd, gnt_disp, gnt_eng, gnt_cpu, gnt_dma, exp_gnt}, 0);
    rst_n = 1;
    m_par = 0; m_we = 0; m_wc = 0; m_wd = 0;
    check({wait_eng, wait_cpu, wait_dma} == 0, "R1 waits clear",
          {wait_eng, wait_cpu, wait_dma}, 0);
  endtask

  task automatic t_parity();
    set_req(0, 0, 0, 0, 0, 0);
    repeat (4) step("R2 idle");
  endtask

  task automatic t_display_only();
    set_req(1, 0, 0, 0, 0, 0);
    repeat (4) step("R4 display");
  endtask

  task automatic t_priority();
    set_req(1, 1, 1, 1, 0, 0);
    repeat (2) step("R5 R3 all");
    set_req(1, 0, 1, 1, 0, 0);
    repeat (2) step("R5 cpu over dma");
    set_req(1, 0, 0, 1, 0, 0);
    repeat (2) step("R5 dma last");
    check(gnt_dma == 1'b1 && slot_odd == 1'b0, "R5 dma got even slot",
          {slot_odd, gnt_dma}, 2'b01);
  endtask

  task automatic t_idle_odd();
    set_req(0, 1, 1, 1, 0, 0);
    repeat (4) step("R4 idle odd");
  endtask

  task automatic t_blank();
    set_req(0, 0, 0, 1, 1, 0);
    repeat (4) step("R6 R7 dma hblank");
    set_req(1, 0, 1, 0, 0, 1);
    repeat (2) step("R6 disp first vblank");
    set_req(0, 0, 1, 1, 0, 1);
    repeat (2) step("R6 cpu vblank");
  endtask

  task automatic t_preempt();
    set_req(0, 0, 0, 1, 1, 1);
    repeat (2) step("R7 dma alone");
    set_req(0, 0, 1, 1, 1, 1);
    step("R7 cpu preempts");
    check(gnt_cpu == 1'b1 && gnt_dma == 1'b0, "R7 dma lost slot",
          {gnt_cpu, gnt_dma}, 2'b10);
    set_req(0, 0, 0, 1, 1, 1);
    step("R7 dma resumes");
  endtask

  task automatic t_wait_sat();
    set_req(0, 1, 0, 1, 0, 0);
    repeat (20) step("R8 starve");
    check(wait_dma == WMAX, "R8 saturate", wait_dma, WMAX);
    set_req(0, 0, 0, 1, 0, 0);
    repeat (2) step("R8 release");
    check(wait_dma == 0, "R8 clear on grant", wait_dma, 0);
  endtask

  task automatic t_exp();
    set_req(0, 0, 1, 0, 0, 0);
    exp_req = 1;
    repeat (2) step("R9 held by cpu");
    req_cpu = 0;
    step("R9 free");
    check(exp_gnt == 1'b1, "R9 exp granted", exp_gnt, 1);
    exp_req = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000 && !done) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=5000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_parity();
    t_display_only();
    t_priority();
    t_idle_odd();
    t_blank();
    t_preempt();
    t_wait_sat();
    t_exp();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule